// File: doc/BRIEF.md
# Four-Phase Handshake Clock-Domain Sender

This block is the sending side of a request/acknowledge crossing between two unrelated clocks. A client in the local domain offers a word with a single-cycle `send_i` pulse. The block captures the word in a register and raises a request level toward the far domain. It keeps the captured word steady on `data_o` for the whole exchange.

The acknowledge from the far side arrives asynchronously. It first passes through a synchronizer chain clocked locally. Once the synchronized acknowledge is seen high, the request is withdrawn. The block then waits for the acknowledge to drop before it reports idle again. The client may offer a new word only while `idle_o` is high. Pulses offered at any other time are discarded.

Top module: `hs_cdc_sender`

## Requirements
- R1: While `rst_ni` is low, and directly after it is released, `idle_o` is 1, `req_o` is 0 and `data_o` is all zeros.
- R2: When `send_i` is 1 at a clock edge where `idle_o` is 1, then after that edge `req_o` is 1, `idle_o` is 0 and `data_o` equals the `send_data_i` value sampled at that edge.
- R3: `data_o` keeps its captured value without change from acceptance until `idle_o` returns to 1, whatever `send_data_i` does meanwhile.
- R4: A `send_i` pulse at an edge where `idle_o` is 0 has no effect. It does not alter `data_o`, and after the block returns to idle `req_o` stays 0 until a fresh pulse arrives.
- R5: `req_o` stays 1 for as long as the acknowledge has not been seen through the two-stage synchronizer. With the default depth, `req_o` falls after the third rising clock edge that follows a rise of `ack_i`.
- R6: After `req_o` falls, `idle_o` stays 0 while `ack_i` remains high. `idle_o` returns to 1 after the third rising clock edge that follows the fall of `ack_i`.
- R7: `idle_o` and `req_o` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| send_i | input | 1 | One-cycle pulse offering a word |
| send_data_i | input | DATA_W | Word offered with `send_i` |
| ack_i | input | 1 | Acknowledge level from the far domain, asynchronous |
| idle_o | output | 1 | High when a new word may be offered |
| req_o | output | 1 | Request level toward the far domain |
| data_o | output | DATA_W | Captured word, held during the exchange |

## Verification
The hardest case to reach is a send pulse that arrives in the last busy cycle, when the synchronized acknowledge has already fallen but the controller has not yet returned to idle. A sender that is off by one cycle would accept that pulse. The bench models the far side with random delays before each acknowledge edge. It sprays random send pulses with fresh data across every busy cycle, and it always forces one pulse into the final busy cycle. After each return to idle, the bench confirms that no request appears and that the captured word did not move.

// File: rtl/hs_cdc_pkg.sv
package hs_cdc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RAISE = 2'd1,
    ST_DROP  = 2'd2
  } hs_state_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int LAST = STAGES - 1;
  logic [LAST:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[0] <= 1'b0;
        else         chain_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= chain_q[g-1];
      end
    end
  end

  assign q_o = chain_q[LAST];
endmodule

// File: rtl/hs_ctrl.sv
module hs_ctrl
  import hs_cdc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic send_i,
  input  logic ack_s_i,
  output logic load_o,
  output logic req_o,
  output logic idle_o
);
  hs_state_e state_q, state_d;
  logic      req_q, req_d;

  assign load_o = (state_q == ST_IDLE) && send_i;

  always_comb begin
    state_d = state_q;
    req_d   = req_q;
    unique case (state_q)
      ST_IDLE: if (send_i) begin
        state_d = ST_RAISE;
        req_d   = 1'b1;
      end
      ST_RAISE: if (ack_s_i) begin
        state_d = ST_DROP;
        req_d   = 1'b0;
      end
      ST_DROP: if (!ack_s_i) state_d = ST_IDLE;
      default: begin
        state_d = ST_IDLE;
        req_d   = 1'b0;
      end
    endcase
  end

  // request kept in its own flop so the crossing level never glitches
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
    end
  end

  assign req_o  = req_q;
  assign idle_o = (state_q == ST_IDLE);
endmodule

// File: rtl/hs_hold.sv
module hs_hold #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_q <= '0;
    else if (load_i) word_q <= d_i;
  end

  assign q_o = word_q;
endmodule

// File: rtl/hs_cdc_sender.sv
module hs_cdc_sender #(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              send_i,
  input  logic [DATA_W-1:0] send_data_i,
  input  logic              ack_i,
  output logic              idle_o,
  output logic              req_o,
  output logic [DATA_W-1:0] data_o
);
  logic ack_s;
  logic load;

  hs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ack_i),
    .q_o   (ack_s)
  );

  hs_ctrl u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .send_i (send_i),
    .ack_s_i(ack_s),
    .load_o (load),
    .req_o  (req_o),
    .idle_o (idle_o)
  );

  hs_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .d_i   (send_data_i),
    .q_o   (data_o)
  );
endmodule

// File: rtl/hs_cdc_sender_chk.sv
module hs_cdc_sender_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              send_i,
  input logic [DATA_W-1:0] send_data_i,
  input logic              ack_i,
  input logic              idle_o,
  input logic              req_o,
  input logic [DATA_W-1:0] data_o
);
  assert_reset_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (idle_o && !req_o && data_o == '0));

  assert_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && send_i) |=> (req_o && !idle_o && data_o == $past(send_data_i)));

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_o |=> (idle_o || $stable(data_o)));

  assert_busy_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_o && !req_o) |=> !req_o);

  assert_req_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_o) |-> $past(ack_i));

  assert_idle_return_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idle_o) |-> !$past(ack_i));

  assert_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(idle_o && req_o));
endmodule

bind hs_cdc_sender hs_cdc_sender_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .send_i     (send_i),
  .send_data_i(send_data_i),
  .ack_i      (ack_i),
  .idle_o     (idle_o),
  .req_o      (req_o),
  .data_o     (data_o)
);

// File: tb/sim_hs_cdc_sender.sv
`timescale 1ns/1ps
module sim_hs_cdc_sender;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         send = 1'b0;
  logic [W-1:0] send_data = '0;
  logic         ack = 1'b0;
  logic         idle, req;
  logic [W-1:0] data;

  int  n_vec  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #2.5 clk = ~clk;

  hs_cdc_sender #(.DATA_W(W), .SYNC_STAGES(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .send_i(send), .send_data_i(send_data),
    .ack_i(ack), .idle_o(idle), .req_o(req), .data_o(data)
  );

  task automatic chk(input bit ok, input string rq, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] pack_st(input logic i, input logic r);
    return {{(W-2){1'b0}}, i, r};
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // random spurious send during a busy cycle
  task automatic spray(input bit force_pulse);
    send      = force_pulse ? 1'b1 : 1'($urandom_range(0, 1));
    send_data = $urandom;
  endtask

  task automatic transfer(input logic [W-1:0] d, input int w_ack, input int w_rel,
                          input bit noisy);
    logic [W-1:0] exp_st;
    send = 1'b1; send_data = d;
    step();
    chk(req && !idle, "R2", pack_st(idle, req), pack_st(1'b0, 1'b1));
    chk(data == d, "R2", data, d);
    send = 1'b0;
    for (int k = 0; k < w_ack; k++) begin
      if (noisy) spray(1'b0);
      step();
      chk(req && !idle, "R5", pack_st(idle, req), pack_st(1'b0, 1'b1));
      chk(data == d, "R3", data, d);
    end
    send = 1'b0;
    ack = 1'b1;
    for (int k = 1; k <= 3; k++) begin
      if (noisy) spray(1'b0);
      step();
      exp_st = pack_st(1'b0, k < 3);
      chk(pack_st(idle, req) == exp_st, "R5", pack_st(idle, req), exp_st);
      chk(!(idle && req), "R7", pack_st(idle, req), exp_st);
    end
    for (int k = 0; k < w_rel; k++) begin
      if (noisy) spray(1'b0);
      step();
      chk(!idle && !req, "R6", pack_st(idle, req), pack_st(1'b0, 1'b0));
      chk(data == d, "R3", data, d);
    end
    send = 1'b0;
    ack = 1'b0;
    for (int k = 1; k <= 3; k++) begin
      // pulse in the final busy cycle must be dropped
      if (noisy || k == 3) spray(k == 3);
      step();
      exp_st = pack_st(k == 3, 1'b0);
      chk(pack_st(idle, req) == exp_st, "R6", pack_st(idle, req), exp_st);
      chk(data == d, "R3", data, d);
    end
    send = 1'b0;
    step();
    chk(idle && !req, "R4", pack_st(idle, req), pack_st(1'b1, 1'b0));
    chk(data == d, "R4", data, d);
  endtask

  initial begin
    void'($urandom(32'd1234));
    #1;
    chk(idle && !req && data == '0, "R1", data, '0);
    repeat (3) step();
    chk(idle && !req && data == '0, "R1", pack_st(idle, req), pack_st(1'b1, 1'b0));
    rst_n = 1'b1;
    step();
    chk(idle && !req && data == '0, "R1", pack_st(idle, req), pack_st(1'b1, 1'b0));
    chk(!(idle && req), "R7", pack_st(idle, req), pack_st(1'b1, 1'b0));

    transfer('0, 0, 0, 1'b0);
    transfer('1, 0, 0, 1'b1);
    transfer(32'hA5A5_5A5A, 4, 2, 1'b1);
    for (int t = 0; t < 60; t++)
      transfer($urandom, $urandom_range(0, 6), $urandom_range(0, 6), 1'($urandom_range(0, 1)));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule